// File: doc/BRIEF.md
# Masked Vector Gather/Scatter Unit

This block is the memory path of a 16-lane vector unit with 32-bit lanes. A gather reads up to sixteen unrelated addresses of a local data memory and builds one vector-register value from the results. A scatter writes the lanes of one vector register to sixteen unrelated addresses. A per-lane mask selects which lanes take part. Lanes that are masked off cause no memory traffic and leave their destination untouched.

The unit converts data formats on the way. Narrow source data (8-bit or 16-bit integers, or half-precision floats held in the low bits of a memory word) is widened to 32 bits when it is gathered. It is narrowed back to that format when it is scattered. The data memory has a single port and a fixed read latency, so the unit handles one active lane per cycle. It works from the lowest lane number upward and skips lanes whose mask bit is clear. When the operation is complete, the unit presents the gathered vector with per-lane write enables for one cycle.

Top module: `vgs_unit`

## Requirements
- R1: The unit accepts `start` only while `busy` is low. After reset `busy`, `done`, `mem_req` and `vr_wen` are low. A `start` raised while busy has no effect on the operation in flight.
- R2: In 32-bit format (`fmt`=0) a gather delivers, for every active lane, the full memory word at that lane's address.
- R3: A lane whose mask bit is 0 causes no memory request. During a gather its `vr_wen` bit stays 0. During a scatter the memory word at its address is not changed.
- R4: Memory requests go out one per cycle with no gaps, in ascending lane order, one request per active lane.
- R5: `done` is a one-cycle pulse. With N active lanes, counting the clock edge that samples `start` as edge 1, a scatter raises `done` after edge N+1 and a gather raises it after edge N+RD_LAT+1.
- R6: A gather with `fmt`=1 takes bits 7:0 of the word and `fmt`=2 takes bits 15:0. The value is sign-extended when `sgn_ext`=1 and zero-extended when `sgn_ext`=0.
- R7: A gather with `fmt`=3 reads bits 15:0 as a half-precision float and widens it exactly to single precision. This covers normals, subnormals, signed zero and infinity. A NaN becomes a quiet single NaN: the exponent is all ones, bit 22 is set, and the low 9 half-mantissa bits land in bits 21:13.
- R8: A scatter with `fmt`=0 writes the whole lane. With `fmt`=1 or `fmt`=2 it writes the lane's low 8 or 16 bits into the word, and the upper word bits are 0.
- R9: A scatter with `fmt`=3 writes the lane's single-precision value as a half in bits 15:0, with bits 31:16 at 0, and rounds toward zero. Results too large become infinity of the same sign. Any NaN becomes 0x7E00 with the sign kept. Results too small for the half subnormal range become signed zero.
- R10: When several active lanes of a scatter share an address, the word left there comes from the highest-numbered of those lanes.
- R11: A `start` with an all-zero mask raises `done` after the sampling edge itself, issues no memory request, and never raises `busy`.
- R12: `vr_wen` is nonzero only in the `done` cycle of a gather, and there it equals the mask of that gather. It stays 0 for a scatter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| is_scatter | input | 1 | 1 = scatter, 0 = gather |
| fmt | input | 2 | Memory format: 0 word, 1 int8, 2 int16, 3 half float |
| sgn_ext | input | 1 | Integer widening: 1 sign, 0 zero extension |
| lane_mask | input | LANES | Active-lane mask, bit i for lane i |
| lane_addr | input | LANES*AW | Per-lane word addresses, lane i in bits i*AW +: AW |
| vr_rdata | input | LANES*32 | Source vector for scatter, lane i in bits i*32 +: 32 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vr_wdata | output | LANES*32 | Gathered vector, valid with `done` |
| vr_wen | output | LANES | Per-lane register write enable, valid with `done` |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, RD_LAT cycles after the request |

## Verification
The bench builds the unit with 16 lanes, a 6-bit address (a 64-word memory) and a read latency of 3. With three stages in the read pipeline, several reads are outstanding at once, so the in-order capture of returned data and the completion timing of R5 are exercised rather than collapsing to a trivial latency of one. The small address space lets the bench place colliding scatter addresses and check every word a test might touch. Conversion corner values are hand-computed constants, covering half subnormals at both ends of the range, overflow and NaN payloads.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

  localparam int ELEM_W = 32;

  typedef enum logic [1:0] {
    FMT_W32 = 2'd0,
    FMT_I8  = 2'd1,
    FMT_I16 = 2'd2,
    FMT_F16 = 2'd3
  } fmt_e;

  // Exact widening of a half-precision value to single precision.
  function automatic logic [31:0] half_to_single(input logic [15:0] h);
    logic        s;
    logic [4:0]  e;
    logic [9:0]  m;
    logic [3:0]  lead;
    logic [10:0] nrm;
    logic [31:0] r;
    s    = h[15];
    e    = h[14:10];
    m    = h[9:0];
    lead = '0;
    nrm  = '0;
    if (e == 5'h1F) begin
      r = (m == 10'h0) ? {s, 8'hFF, 23'h0} : {s, 8'hFF, 1'b1, m[8:0], 13'h0};
    end else if (e != 5'h0) begin
      r = {s, ({3'b000, e} + 8'd112), m, 13'h0};
    end else if (m == 10'h0) begin
      r = {s, 31'h0};
    end else begin
      for (int i = 0; i < 10; i++) begin
        if (m[i]) lead = 4'(i);
      end
      nrm = {1'b0, m} << (4'd10 - lead);
      r   = {s, ({4'b0000, lead} + 8'd103), nrm[9:0], 13'h0};
    end
    return r;
  endfunction

  // Single to half, rounding toward zero; overflow to infinity.
  function automatic logic [15:0] single_to_half(input logic [31:0] f);
    logic        s;
    logic [7:0]  e;
    logic [22:0] m;
    logic [23:0] sig;
    logic [15:0] r;
    s   = f[31];
    e   = f[30:23];
    m   = f[22:0];
    sig = '0;
    if (e == 8'hFF) begin
      r = (m == 23'h0) ? {s, 5'h1F, 10'h0} : {s, 5'h1F, 10'h200};
    end else if (e > 8'd142) begin
      r = {s, 5'h1F, 10'h0};
    end else if (e >= 8'd113) begin
      r = {s, 5'(e - 8'd112), m[22:13]};
    end else if (e >= 8'd103) begin
      sig = {1'b1, m} >> (8'd126 - e);
      r   = {s, 5'd0, sig[9:0]};
    end else begin
      r = {s, 15'h0};
    end
    return r;
  endfunction

endpackage

// File: rtl/vgs_lane_pick.sv
module vgs_lane_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0]         req,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx,
  output logic [N-1:0]         onehot
);
  always_comb begin
    any    = |req;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx    = ($clog2(N))'(i);
        onehot = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/vgs_widen.sv
module vgs_widen
  import vgs_pkg::*;
(
  input  fmt_e        fmt,
  input  logic        sgn,
  input  logic [31:0] word,
  output logic [31:0] elem
);
  always_comb begin
    unique case (fmt)
      FMT_I8:  elem = sgn ? {{24{word[7]}}, word[7:0]} : {24'h0, word[7:0]};
      FMT_I16: elem = sgn ? {{16{word[15]}}, word[15:0]} : {16'h0, word[15:0]};
      FMT_F16: elem = half_to_single(word[15:0]);
      default: elem = word;
    endcase
  end
endmodule

// File: rtl/vgs_narrow.sv
module vgs_narrow
  import vgs_pkg::*;
(
  input  fmt_e        fmt,
  input  logic [31:0] elem,
  output logic [31:0] word
);
  always_comb begin
    unique case (fmt)
      FMT_I8:  word = {24'h0, elem[7:0]};
      FMT_I16: word = {16'h0, elem[15:0]};
      FMT_F16: word = {16'h0, single_to_half(elem)};
      default: word = elem;
    endcase
  end
endmodule

// File: rtl/vgs_unit.sv
module vgs_unit
  import vgs_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int AW     = 10,
  parameter int RD_LAT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     is_scatter,
  input  logic [1:0]               fmt,
  input  logic                     sgn_ext,
  input  logic [LANES-1:0]         lane_mask,
  input  logic [LANES*AW-1:0]      lane_addr,
  input  logic [LANES*ELEM_W-1:0]  vr_rdata,
  output logic                     busy,
  output logic                     done,
  output logic [LANES*ELEM_W-1:0]  vr_wdata,
  output logic [LANES-1:0]         vr_wen,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [ELEM_W-1:0]        mem_wdata,
  input  logic [ELEM_W-1:0]        mem_rdata
);
  localparam int EW = ELEM_W;
  localparam int LW = $clog2(LANES);
  localparam logic [RD_LAT-1:0] PIPE_HEAD = RD_LAT'(1) << (RD_LAT - 1);

  // operation state
  logic             busy_q, done_q, op_sc_q, sgn_q;
  fmt_e             fmt_q;
  logic [LANES-1:0] pend_q, mask_q, wen_q;
  logic [AW-1:0]    addr_q [LANES];
  logic [EW-1:0]    data_q [LANES];
  logic [EW-1:0]    res_q  [LANES];
  logic [RD_LAT-1:0] pv_q;
  logic [LW-1:0]    pl_q [RD_LAT];

  // lane selection
  logic             pick_any;
  logic [LW-1:0]    pick_idx;
  logic [LANES-1:0] pick_oh;

  vgs_lane_pick #(.N(LANES)) u_pick (
    .req    (pend_q),
    .any    (pick_any),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  // named internal events
  logic accept_ev, zero_ev, issue_ev, last_issue, cap_ev, finish_ev;
  assign accept_ev  = start && !busy_q;
  assign zero_ev    = accept_ev && (lane_mask == '0);
  assign issue_ev   = busy_q && pick_any;
  assign last_issue = issue_ev && ((pend_q & ~pick_oh) == '0);
  assign cap_ev     = pv_q[RD_LAT-1];
  assign finish_ev  = busy_q && (op_sc_q ? last_issue
                                         : (cap_ev && ((pv_q & ~PIPE_HEAD) == '0) && (pend_q == '0)));

  // format conversion
  logic [EW-1:0] wid_elem, nar_word;

  vgs_widen u_wid (
    .fmt  (fmt_q),
    .sgn  (sgn_q),
    .word (mem_rdata),
    .elem (wid_elem)
  );

  vgs_narrow u_nar (
    .fmt  (fmt_q),
    .elem (data_q[pick_idx]),
    .word (nar_word)
  );

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      op_sc_q <= 1'b0;
      sgn_q   <= 1'b0;
      fmt_q   <= FMT_W32;
      pend_q  <= '0;
      mask_q  <= '0;
      wen_q   <= '0;
      pv_q    <= '0;
    end else begin
      done_q <= zero_ev || finish_ev;
      wen_q  <= (finish_ev && !op_sc_q) ? mask_q : '0;
      pv_q   <= (pv_q << 1) | RD_LAT'(issue_ev && !op_sc_q);
      if (accept_ev) begin
        busy_q  <= (lane_mask != '0);
        pend_q  <= lane_mask;
        mask_q  <= lane_mask;
        op_sc_q <= is_scatter;
        sgn_q   <= sgn_ext;
        fmt_q   <= fmt_e'(fmt);
      end else begin
        if (issue_ev)  pend_q <= pend_q & ~pick_oh;
        if (finish_ev) busy_q <= 1'b0;
      end
    end
  end

  // operand capture, read tag pipeline, result assembly
  always_ff @(posedge clk) begin
    if (accept_ev) begin
      for (int i = 0; i < LANES; i++) begin
        addr_q[i] <= lane_addr[i*AW +: AW];
        data_q[i] <= vr_rdata[i*EW +: EW];
      end
    end
    pl_q[0] <= pick_idx;
    for (int i = 1; i < RD_LAT; i++) begin
      pl_q[i] <= pl_q[i-1];
    end
    if (cap_ev) begin
      res_q[pl_q[RD_LAT-1]] <= wid_elem;
    end
  end

  // outputs
  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign vr_wdata[g*EW +: EW] = res_q[g];
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign vr_wen    = wen_q;
  assign mem_req   = issue_ev;
  assign mem_we    = op_sc_q;
  assign mem_addr  = addr_q[pick_idx];
  assign mem_wdata = nar_word;

endmodule

// File: rtl/vgs_chk.sv
module vgs_chk #(
  parameter int LANES = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     busy,
  input logic                     done,
  input logic [LANES-1:0]         lane_mask,
  input logic [LANES-1:0]         vr_wen,
  input logic                     mem_req,
  input logic                     issue_ev,
  input logic                     last_issue,
  input logic [$clog2(LANES)-1:0] issue_idx,
  input logic                     op_sc
);
  logic [LANES-1:0] mask_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_seen <= '0;
    else if (start && !busy) mask_seen <= lane_mask;
  end

  // R4
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R4
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ev && !last_issue |=> issue_ev && (issue_idx > $past(issue_idx)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  // R11
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (lane_mask == '0) |=> done && !busy && !mem_req);

  // R12
  wen_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !op_sc |-> vr_wen == mask_seen);

  // R12
  wen_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_wen != '0) |-> done && !op_sc);

endmodule

bind vgs_unit vgs_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .lane_mask  (lane_mask),
  .vr_wen     (vr_wen),
  .mem_req    (mem_req),
  .issue_ev   (issue_ev),
  .last_issue (last_issue),
  .issue_idx  (pick_idx),
  .op_sc      (op_sc_q)
);

// File: tb/sim_vgs_unit.sv
`timescale 1ns/1ps
module sim_vgs_unit;
  localparam int LN  = 16;
  localparam int AWB = 6;
  localparam int LAT = 3;
  localparam int MW  = 1 << AWB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              start = 1'b0, is_scatter = 1'b0, sgn_ext = 1'b0;
  logic [1:0]        fmt = 2'd0;
  logic [LN-1:0]     lane_mask = '0;
  logic [LN*AWB-1:0] lane_addr;
  logic [LN*32-1:0]  vr_rdata;
  logic              busy, done, mem_req, mem_we;
  logic [LN*32-1:0]  vr_wdata;
  logic [LN-1:0]     vr_wen;
  logic [AWB-1:0]    mem_addr;
  logic [31:0]       mem_wdata, mem_rdata;

  logic [AWB-1:0] la [LN];
  logic [31:0]    vr [LN];
  logic [31:0]    mem [MW];
  logic [31:0]    rp [LAT];
  logic [AWB-1:0] log_addr [64];
  logic           log_we [64];
  int             log_n = 0;
  int             n_cmp = 0, n_bad = 0;

  for (genvar g = 0; g < LN; g++) begin : g_pack
    assign lane_addr[g*AWB +: AWB] = la[g];
    assign vr_rdata[g*32 +: 32]    = vr[g];
  end

  vgs_unit #(.LANES(LN), .AW(AWB), .RD_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_scatter(is_scatter),
    .fmt(fmt), .sgn_ext(sgn_ext), .lane_mask(lane_mask), .lane_addr(lane_addr),
    .vr_rdata(vr_rdata), .busy(busy), .done(done), .vr_wdata(vr_wdata),
    .vr_wen(vr_wen), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: fixed read latency LAT
  assign mem_rdata = rp[LAT-1];
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    rp[0] <= mem[mem_addr];
    for (int i = 1; i < LAT; i++) rp[i] <= rp[i-1];
    if (mem_req && log_n < 64) begin
      log_addr[log_n] = mem_addr;
      log_we[log_n]   = mem_we;
      log_n++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    if (done) begin
      for (int i = 0; i < LN; i++) if (vr_wen[i]) vr[i] = vr_wdata[i*32 +: 32];
    end
  endtask

  task automatic launch(input logic sc, input logic [1:0] f, input logic sg,
                        input logic [LN-1:0] m, output int cyc, output logic [LN-1:0] wen);
    @(negedge clk);
    log_n = 0;
    is_scatter = sc; fmt = f; sgn_ext = sg; lane_mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    wen = vr_wen;
  endtask

  // check the request log against ascending active lanes
  task automatic chk_order(input string req, input logic [LN-1:0] m, input logic we);
    int j;
    j = 0;
    chk(req, "request count", 32'(log_n), 32'($countones(m)));
    for (int i = 0; i < LN; i++) begin
      if (m[i] && j < log_n) begin
        chk(req, $sformatf("request %0d address", j), 32'(log_addr[j]), 32'(la[i]));
        chk(req, $sformatf("request %0d write", j), 32'(log_we[j]), 32'(we));
        j++;
      end
    end
  endtask

  function automatic logic [15:0] h_in(input int k);
    case (k % 10)
      0: return 16'h3C00; 1: return 16'hC000; 2: return 16'h0001; 3: return 16'h0200;
      4: return 16'h7C00; 5: return 16'hFC00; 6: return 16'h7C01; 7: return 16'h8000;
      8: return 16'h3555; default: return 16'h0003;
    endcase
  endfunction
  function automatic logic [31:0] h_exp(input int k);
    case (k % 10)
      0: return 32'h3F800000; 1: return 32'hC0000000; 2: return 32'h33800000; 3: return 32'h38000000;
      4: return 32'h7F800000; 5: return 32'hFF800000; 6: return 32'h7FC02000; 7: return 32'h80000000;
      8: return 32'h3EAAA000; default: return 32'h34400000;
    endcase
  endfunction
  function automatic logic [31:0] s_in(input int k);
    case (k % 10)
      0: return 32'h3F800000; 1: return 32'hBF800000; 2: return 32'h477FE000; 3: return 32'h47800000;
      4: return 32'h7FC00000; 5: return 32'h33800000; 6: return 32'h38000000; 7: return 32'hB3000000;
      8: return 32'hFF800000; default: return 32'h3EAAAAAB;
    endcase
  endfunction
  function automatic logic [15:0] s_exp(input int k);
    case (k % 10)
      0: return 16'h3C00; 1: return 16'hBC00; 2: return 16'h7BFF; 3: return 16'h7C00;
      4: return 16'h7E00; 5: return 16'h0001; 6: return 16'h0200; 7: return 16'h8000;
      8: return 16'hFC00; default: return 16'h3555;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1", "busy after reset", 32'(busy), 0);
    chk("R1", "done after reset", 32'(done), 0);
    chk("R1", "mem_req after reset", 32'(mem_req), 0);
    chk("R1", "vr_wen after reset", 32'(vr_wen), 0);
  endtask

  task automatic t_gather_word();
    int cyc; logic [LN-1:0] wen;
    for (int k = 0; k < MW; k++) mem[k] = 32'h5A000000 + 32'(k) * 32'h00010101;
    for (int i = 0; i < LN; i++) la[i] = AWB'((i * 7 + 5) % MW);
    launch(1'b0, 2'd0, 1'b0, 16'hFFFF, cyc, wen);
    for (int i = 0; i < LN; i++)
      chk("R2", $sformatf("lane %0d word", i), vr[i], 32'h5A000000 + 32'(la[i]) * 32'h00010101);
    chk("R5", "gather cycles full mask", 32'(cyc), 32'(LN + LAT + 1));
    chk_order("R4", 16'hFFFF, 1'b0);
    chk("R12", "vr_wen full", 32'(wen), 32'hFFFF);
  endtask

  task automatic t_gather_mask();
    int cyc; logic [LN-1:0] wen; logic [LN-1:0] m;
    m = 16'hA5C3;
    for (int i = 0; i < LN; i++) begin
      la[i] = AWB'(i * 3 + 1);
      vr[i] = 32'hBAD00000 + 32'(i);
    end
    launch(1'b0, 2'd0, 1'b0, m, cyc, wen);
    for (int i = 0; i < LN; i++)
      chk("R3", $sformatf("masked gather lane %0d", i), vr[i],
          m[i] ? 32'h5A000000 + 32'(la[i]) * 32'h00010101 : 32'hBAD00000 + 32'(i));
    chk("R5", "gather cycles partial", 32'(cyc), 32'($countones(m) + LAT + 1));
    chk_order("R4", m, 1'b0);
    chk("R12", "vr_wen partial", 32'(wen), 32'(m));
  endtask

  task automatic t_gather_int();
    int cyc; logic [LN-1:0] wen; logic [31:0] w;
    for (int i = 0; i < LN; i++) begin
      la[i]  = AWB'(i);
      mem[i] = 32'h12340000 | ((i % 2 == 1) ? 32'h8080 : 32'h0000) | (32'(i) * 32'h0101);
    end
    for (int sg = 0; sg < 2; sg++) begin
      launch(1'b0, 2'd1, sg[0], 16'hFFFF, cyc, wen);
      for (int i = 0; i < LN; i++) begin
        w = mem[i];
        chk("R6", $sformatf("int8 sgn%0d lane %0d", sg, i), vr[i],
            (sg == 1 && w[7]) ? (32'hFFFFFF00 | w[7:0]) : {24'h0, w[7:0]});
      end
      launch(1'b0, 2'd2, sg[0], 16'hFFFF, cyc, wen);
      for (int i = 0; i < LN; i++) begin
        w = mem[i];
        chk("R6", $sformatf("int16 sgn%0d lane %0d", sg, i), vr[i],
            (sg == 1 && w[15]) ? (32'hFFFF0000 | w[15:0]) : {16'h0, w[15:0]});
      end
    end
  endtask

  task automatic t_gather_half();
    int cyc; logic [LN-1:0] wen;
    for (int i = 0; i < LN; i++) begin
      la[i] = AWB'(20 + i);
      mem[20 + i] = {16'hABCD, h_in(i)};
    end
    launch(1'b0, 2'd3, 1'b1, 16'hFFFF, cyc, wen);
    for (int i = 0; i < LN; i++)
      chk("R7", $sformatf("half lane %0d", i), vr[i], h_exp(i));
  endtask

  task automatic t_scatter_word();
    int cyc; logic [LN-1:0] wen; logic [LN-1:0] m;
    m = 16'h3C0F;
    for (int k = 0; k < MW; k++) mem[k] = 32'hEEEE0000 + 32'(k);
    for (int i = 0; i < LN; i++) begin
      la[i] = AWB'(i * 4);
      vr[i] = 32'hCAFE0000 + 32'(i);
    end
    launch(1'b1, 2'd0, 1'b0, m, cyc, wen);
    for (int i = 0; i < LN; i++)
      chk(m[i] ? "R8" : "R3", $sformatf("scatter word lane %0d", i), mem[la[i]],
          m[i] ? 32'hCAFE0000 + 32'(i) : 32'hEEEE0000 + 32'(la[i]));
    chk("R5", "scatter cycles", 32'(cyc), 32'($countones(m) + 1));
    chk_order("R4", m, 1'b1);
    chk("R12", "vr_wen scatter", 32'(wen), 0);
  endtask

  task automatic t_scatter_int();
    int cyc; logic [LN-1:0] wen;
    for (int i = 0; i < LN; i++) begin
      la[i] = AWB'(i);
      vr[i] = 32'h89ABCDEF ^ (32'(i) * 32'h11111111);
    end
    launch(1'b1, 2'd1, 1'b1, 16'hFFFF, cyc, wen);
    for (int i = 0; i < LN; i++)
      chk("R8", $sformatf("int8 store lane %0d", i), mem[i], vr[i] & 32'h000000FF);
    launch(1'b1, 2'd2, 1'b0, 16'hFFFF, cyc, wen);
    for (int i = 0; i < LN; i++)
      chk("R8", $sformatf("int16 store lane %0d", i), mem[i], vr[i] & 32'h0000FFFF);
  endtask

  task automatic t_scatter_half();
    int cyc; logic [LN-1:0] wen;
    for (int i = 0; i < LN; i++) begin
      la[i] = AWB'(40 + i);
      vr[i] = s_in(i);
      mem[40 + i] = 32'hFFFFFFFF;
    end
    launch(1'b1, 2'd3, 1'b0, 16'hFFFF, cyc, wen);
    for (int i = 0; i < LN; i++)
      chk("R9", $sformatf("half store lane %0d", i), mem[40 + i], {16'h0, s_exp(i)});
  endtask

  task automatic t_dup();
    int cyc; logic [LN-1:0] wen;
    for (int i = 0; i < LN; i++) begin
      la[i] = AWB'(9);
      vr[i] = 32'h0D0D0000 + 32'(i);
    end
    launch(1'b1, 2'd0, 1'b0, 16'h0616, cyc, wen);
    chk("R10", "shared address keeps lane 10", mem[9], 32'h0D0D000A);
  endtask

  task automatic t_zero();
    int cyc; logic [LN-1:0] wen;
    for (int i = 0; i < LN; i++) vr[i] = 32'h77770000 + 32'(i);
    launch(1'b0, 2'd0, 1'b0, 16'h0000, cyc, wen);
    chk("R11", "zero-mask gather cycles", 32'(cyc), 1);
    chk("R11", "zero-mask gather requests", 32'(log_n), 0);
    chk("R11", "zero-mask vr lane 5 kept", vr[5], 32'h77770005);
    launch(1'b1, 2'd0, 1'b0, 16'h0000, cyc, wen);
    chk("R11", "zero-mask scatter cycles", 32'(cyc), 1);
    chk("R11", "zero-mask scatter requests", 32'(log_n), 0);
    chk("R11", "busy after zero mask", 32'(busy), 0);
  endtask

  task automatic t_busy_start();
    int cyc;
    for (int i = 0; i < LN; i++) begin
      la[i] = AWB'(i);
      mem[i] = 32'h31000000 + 32'(i);
      vr[i] = 32'h66000000 + 32'(i);
    end
    @(negedge clk);
    log_n = 0;
    is_scatter = 1'b0; fmt = 2'd0; lane_mask = 16'h0011; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    is_scatter = 1'b1; lane_mask = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk("R1", "requests with start while busy", 32'(log_n), 2);
    chk("R1", "lane 0 from first op", vr[0], 32'h31000000);
    chk("R1", "lane 4 from first op", vr[4], 32'h31000004);
    chk("R1", "lane 1 untouched", vr[1], 32'h66000001);
    chk("R1", "memory lane 1 untouched", mem[1], 32'h31000001);
  endtask

  initial begin
    for (int i = 0; i < LN; i++) begin la[i] = '0; vr[i] = '0; end
    for (int k = 0; k < MW; k++) mem[k] = '0;
    for (int i = 0; i < LAT; i++) rp[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gather_word();
    t_gather_mask();
    t_gather_int();
    t_gather_half();
    t_scatter_word();
    t_scatter_int();
    t_scatter_half();
    t_dup();
    t_zero();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule